// File: doc/BRIEF.md
# Microcoded Field-Operation Sequencer

This block is the controller of a field-arithmetic processor. Each routine is a short program of 20-bit microwords held in an internal ROM. The ROM contents come from a parameter array. When idle, the sequencer accepts a start request together with a ROM entry address. It then steps through the microwords one per cycle. Each microword drives:

- two 5-bit read/write addresses of the register RAM;
- a 2-bit RAM write-enable field;
- three operand-load strobes for the arithmetic units;
- a 3-bit unit-output select, decoded into one-hot output enables.

The two top bits of each microword steer the controller. The word can advance, stall for a full multiplication, or end the routine.

A host picks the entry address from the scalar bits being processed. For example, it starts a doubling routine or an addition routine. It waits for `done` and then issues the next start. During a multiply stall the sequencer drives no RAM write, no load and no unit output for exactly PB+3 cycles. PB is the field size in bits. The next microword then issues.

Top module: `fop_seq`

## Requirements
- R1: During and right after reset, `busy`, `done` and `mul_wait` are 0, and `ram_we`, `unit_oe`, `unit_load`, `ram_addr_a` and `ram_addr_b` are all 0.
- R2: When `start` is high at a clock edge while `busy` is 0, the microword at `start_addr` issues in the cycle that follows that edge, and `busy` is 1 in that cycle.
- R3: In an issue cycle the microword fields drive the outputs directly:
  - bits 19:18 are the control code;
  - bits 17:15 drive `unit_load`;
  - bits 14:12 are the unit select;
  - bits 11:10 drive `ram_we`;
  - bits 9:5 drive `ram_addr_a`;
  - bits 4:0 drive `ram_addr_b`.
- R4: Unit select 0 enables no unit. A select value n from 1 to NUM_UNITS sets only bit n-1 of `unit_oe`. A value above NUM_UNITS enables no unit. At most one bit of `unit_oe` is ever high.
- R5: Control codes 00 and 11 both advance: the microword at the next ROM address issues in the following cycle.
- R6: Control code 01 issues its fields for one cycle. Exactly PB+3 wait cycles follow, with `mul_wait` and `busy` high and `ram_we`, `unit_oe` and `unit_load` all 0. The microword at the next address then issues.
- R7: Control code 10 issues its fields with `done` high for that single cycle. In the following cycle `busy` and `done` are 0.
- R8: A `start` while `busy` is 1 is ignored: the running routine continues with the same sequence of microwords.
- R9: Stepping past the last ROM address (DEPTH-1) continues at address 0.
- R10: Whenever no microword issues (idle or multiply wait), `ram_we`, `unit_oe`, `unit_load` and both RAM addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run a routine, honoured only while idle |
| start_addr | input | $clog2(DEPTH) | ROM address of the routine's first microword |
| busy | output | 1 | A routine is running (issue or wait) |
| done | output | 1 | High in the issue cycle of the ending microword |
| mul_wait | output | 1 | Multiply wait cycle in progress |
| ram_addr_a | output | 5 | RAM port A address |
| ram_addr_b | output | 5 | RAM port B address |
| ram_we | output | 2 | RAM write-enable field |
| unit_oe | output | NUM_UNITS | One-hot unit output enables |
| unit_load | output | 3 | Operand-load strobes to the arithmetic units |

## Verification
The bench models every routine cycle by cycle from its own ROM image. It compares each issue, wait and trailing idle cycle against that model, so the checks catch the following faults:

- A stall one cycle short or long shifts every later microword.
- Treating code 11 as an end or a stall breaks the second routine.
- A select decoded off by one, or not masked above NUM_UNITS, shows on `unit_oe` in the select-6 and select-7 words.

A routine placed at the top of the ROM checks that the address wraps to 0 rather than stopping. Starts injected mid-routine, including one during a multiply wait, would redirect the program counter in a design that reloads it while busy.

// File: rtl/fop_seq_pkg.sv
`timescale 1ns/1ps
package fop_seq_pkg;

   // Microword layout (MSB first); the ordering is decoded by the sequencer.
   localparam int unsigned CTW  = 2;   // control code
   localparam int unsigned LDW  = 3;   // unit load strobes
   localparam int unsigned SELW = 3;   // encoded unit select
   localparam int unsigned WEW  = 2;   // RAM write enables
   localparam int unsigned RAW  = 5;   // each RAM address field
   localparam int unsigned IW   = CTW + LDW + SELW + WEW + 2 * RAW;
   localparam int unsigned MAX_UNITS = (1 << SELW) - 1;

   typedef enum logic [CTW-1:0] {
      CT_NEXT = 2'b00,
      CT_MUL  = 2'b01,
      CT_END  = 2'b10,
      CT_RSV  = 2'b11
   } ctrl_e;

   typedef struct packed {
      ctrl_e             ctrl;
      logic [LDW-1:0]    load;
      logic [SELW-1:0]   sel;
      logic [WEW-1:0]    we;
      logic [RAW-1:0]    addr_a;
      logic [RAW-1:0]    addr_b;
   } uword_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_e;

   // Filler word: ends a routine with every field quiet.
   localparam logic [IW-1:0] END_WORD = {CT_END, {(IW-CTW){1'b0}}};

endpackage

// File: rtl/fop_seq_rom.sv
`timescale 1ns/1ps
module fop_seq_rom
   import fop_seq_pkg::*;
#(
   parameter int unsigned   DEPTH = 32,
   parameter int unsigned   AW    = 5,
   parameter logic [IW-1:0] PROGRAM [DEPTH] = '{default: END_WORD}
) (
   input  logic [AW-1:0] addr,
   output uword_t        word
);

   generate
      if ((1 << AW) == DEPTH) begin : g_full
         // Every address maps to a stored word.
         assign word = uword_t'(PROGRAM[addr]);
      end else begin : g_partial
         // Addresses past the end read as a routine terminator.
         logic in_range;
         assign in_range = (32'(addr) < DEPTH);
         assign word = in_range ? uword_t'(PROGRAM[addr]) : uword_t'(END_WORD);
      end
   endgenerate

endmodule

// File: rtl/fop_seq_sel_dec.sv
`timescale 1ns/1ps
module fop_seq_sel_dec
   import fop_seq_pkg::*;
#(
   parameter int unsigned NUM_UNITS = 7
) (
   input  logic                 en,
   input  logic [SELW-1:0]      sel,
   output logic [NUM_UNITS-1:0] oe
);

   // Code 0 is "bus released"; code n enables unit n (bit n-1).
   generate
      for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
         localparam logic [SELW-1:0] CODE = SELW'(g + 1);
         assign oe[g] = en && (sel == CODE);
      end
   endgenerate

endmodule

// File: rtl/fop_seq_wait.sv
`timescale 1ns/1ps
module fop_seq_wait #(
   parameter int unsigned STALL_CYC = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic run,
   output logic last
);

   localparam int unsigned CW = (STALL_CYC > 1) ? $clog2(STALL_CYC) : 1;
   localparam logic [CW-1:0] INIT = CW'(STALL_CYC - 1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (arm) begin
         remain <= INIT;
      end else if (run && (remain != '0)) begin
         remain <= remain - 1'b1;
      end
   end

   assign last = (remain == '0);

endmodule

// File: rtl/fop_seq.sv
`timescale 1ns/1ps
module fop_seq
   import fop_seq_pkg::*;
#(
   parameter int unsigned   PB        = 8,
   parameter int unsigned   DEPTH     = 32,
   parameter int unsigned   NUM_UNITS = 7,
   parameter logic [IW-1:0] PROGRAM [DEPTH] = '{default: END_WORD},
   localparam int unsigned  AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [AW-1:0]        start_addr,
   output logic                 busy,
   output logic                 done,
   output logic                 mul_wait,
   output logic [RAW-1:0]       ram_addr_a,
   output logic [RAW-1:0]       ram_addr_b,
   output logic [WEW-1:0]       ram_we,
   output logic [NUM_UNITS-1:0] unit_oe,
   output logic [LDW-1:0]       unit_load
);

   localparam int unsigned  STALL_CYC = PB + 3;
   localparam logic [AW-1:0] LAST_PC  = AW'(DEPTH - 1);

   // Elaboration-time parameter checks
   generate
      if (PB < 1) begin : g_bad_pb
         $error("fop_seq: PB must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("fop_seq: DEPTH must be at least 2");
      end
      if ((NUM_UNITS < 1) || (NUM_UNITS > MAX_UNITS)) begin : g_bad_units
         $error("fop_seq: NUM_UNITS must lie in 1..7");
      end
   endgenerate

   seq_state_e    state;
   logic [AW-1:0] pc;
   uword_t        word;
   logic          issue;
   logic          wait_last;
   logic          arm_wait;
   logic [AW-1:0] pc_inc;

   fop_seq_rom #(
      .DEPTH   (DEPTH),
      .AW      (AW),
      .PROGRAM (PROGRAM)
   ) u_rom (
      .addr (pc),
      .word (word)
   );

   fop_seq_wait #(
      .STALL_CYC (STALL_CYC)
   ) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (arm_wait),
      .run   (mul_wait),
      .last  (wait_last)
   );

   fop_seq_sel_dec #(
      .NUM_UNITS (NUM_UNITS)
   ) u_dec (
      .en  (issue),
      .sel (word.sel),
      .oe  (unit_oe)
   );

   assign issue    = (state == ST_ISSUE);
   assign arm_wait = issue && (word.ctrl == CT_MUL);
   assign pc_inc   = (pc == LAST_PC) ? '0 : pc + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pc    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  pc    <= start_addr;
                  state <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               unique case (word.ctrl)
                  CT_END:  state <= ST_IDLE;
                  CT_MUL:  state <= ST_WAIT;
                  default: pc    <= pc_inc;
               endcase
            end
            ST_WAIT: begin
               if (wait_last) begin
                  pc    <= pc_inc;
                  state <= ST_ISSUE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy       = (state != ST_IDLE);
      mul_wait   = (state == ST_WAIT);
      done       = issue && (word.ctrl == CT_END);
      ram_addr_a = issue ? word.addr_a : '0;
      ram_addr_b = issue ? word.addr_b : '0;
      ram_we     = issue ? word.we     : '0;
      unit_load  = issue ? word.load   : '0;
   end

endmodule

// File: rtl/fop_seq_chk.sv
`timescale 1ns/1ps
module fop_seq_chk #(
   parameter int unsigned NUM_UNITS = 7,
   parameter int unsigned STALL_CYC = 11
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 busy,
   input logic                 done,
   input logic                 mul_wait,
   input logic [1:0]           ram_we,
   input logic [NUM_UNITS-1:0] unit_oe,
   input logic [2:0]           unit_load
);

   int unsigned wait_run;

   always_ff @(posedge clk) begin
      if (!rst_n)        wait_run <= 0;
      else if (mul_wait) wait_run <= wait_run + 1;
      else               wait_run <= 0;
   end

   p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   p_oe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(unit_oe));

   p_wait_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mul_wait |-> (wait_run < STALL_CYC));

   p_wait_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mul_wait) |-> ($past(wait_run) == STALL_CYC - 1));

   p_wait_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mul_wait |-> (ram_we == '0 && unit_load == '0 && unit_oe == '0 && busy));

   p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));

   p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ram_we == '0 && unit_load == '0 && unit_oe == '0 && !done && !mul_wait));

endmodule

bind fop_seq fop_seq_chk #(
   .NUM_UNITS (NUM_UNITS),
   .STALL_CYC (STALL_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .mul_wait  (mul_wait),
   .ram_we    (ram_we),
   .unit_oe   (unit_oe),
   .unit_load (unit_load)
);

// File: tb/tb_fop_seq.sv
`timescale 1ns/1ps
module tb_fop_seq;

   localparam int PB    = 5;
   localparam int DEPTH = 32;
   localparam int NU    = 5;
   localparam int STALL = PB + 3;
   localparam int AW    = 5;

   // Bench ROM image: {ctrl, load, sel, we, addr_a, addr_b}
   localparam logic [19:0] PROG [DEPTH] = '{
      0:  {2'b00, 3'b001, 3'd1, 2'b01, 5'd3,  5'd4},
      1:  {2'b01, 3'b010, 3'd0, 2'b00, 5'd5,  5'd6},
      2:  {2'b00, 3'b000, 3'd2, 2'b10, 5'd7,  5'd8},
      3:  {2'b10, 3'b100, 3'd7, 2'b01, 5'd9,  5'd10},
      5:  {2'b11, 3'b011, 3'd3, 2'b11, 5'd1,  5'd2},
      6:  {2'b00, 3'b000, 3'd0, 2'b00, 5'd31, 5'd0},
      7:  {2'b01, 3'b111, 3'd5, 2'b00, 5'd2,  5'd2},
      8:  {2'b10, 3'b000, 3'd4, 2'b10, 5'd0,  5'd31},
      29: {2'b00, 3'b001, 3'd6, 2'b01, 5'd11, 5'd12},
      30: {2'b01, 3'b000, 3'd0, 2'b00, 5'd13, 5'd14},
      31: {2'b00, 3'b010, 3'd1, 2'b11, 5'd15, 5'd16},
      default: 20'h80000
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          busy, done, mul_wait;
   logic [4:0]    ram_addr_a, ram_addr_b;
   logic [1:0]    ram_we;
   logic [NU-1:0] unit_oe;
   logic [2:0]    unit_load;

   always #2.5 clk = ~clk;

   fop_seq #(
      .PB        (PB),
      .DEPTH     (DEPTH),
      .NUM_UNITS (NU),
      .PROGRAM   (PROG)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_addr (start_addr),
      .busy       (busy),
      .done       (done),
      .mul_wait   (mul_wait),
      .ram_addr_a (ram_addr_a),
      .ram_addr_b (ram_addr_b),
      .ram_we     (ram_we),
      .unit_oe    (unit_oe),
      .unit_load  (unit_load)
   );

   typedef struct packed {
      logic [3:0]    req;
      logic [1:0]    we;
      logic [4:0]    a;
      logic [4:0]    b;
      logic [NU-1:0] oe;
      logic [2:0]    ld;
      logic          dn;
      logic          mw;
      logic          bz;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   finished = 0;

   task automatic chk(input int req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL R%0d %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [NU-1:0] sel_oe(input logic [2:0] s);
      if (s >= 1 && int'(s) <= NU) return NU'(1) << (s - 1);
      return '0;
   endfunction

   task automatic push(input int req, input logic [19:0] w, input bit iss,
                       input bit mw, input bit bz);
      exp_t e;
      e.req = 4'(req);
      e.we  = iss ? w[11:10] : 2'b0;
      e.a   = iss ? w[9:5]   : 5'd0;
      e.b   = iss ? w[4:0]   : 5'd0;
      e.oe  = iss ? sel_oe(w[14:12]) : '0;
      e.ld  = iss ? w[17:15] : 3'b0;
      e.dn  = iss && (w[19:18] == 2'b10);
      e.mw  = mw;
      e.bz  = bz;
      q.push_back(e);
   endtask

   // Driver side: expected trace of one routine, built from the requirements.
   task automatic plan(input int addr, input int tag_over);
      int          pc;
      int          req;
      bit          first;
      bit          wrapped;
      logic [19:0] w;
      pc = addr; first = 1; wrapped = 0;
      for (int step = 0; step < 64; step++) begin
         w = PROG[pc];
         if (first)                   req = 2;       // R2 first word
         else if (w[19:18] == 2'b10)  req = 7;       // R7 ending word
         else if (wrapped)            req = 9;       // R9 past the wrap
         else if (tag_over != 0)      req = tag_over;
         else if (w[19:18] == 2'b11)  req = 5;       // R5 reserved code
         else                         req = 3;       // R3 field mapping
         push(req, w, 1'b1, 1'b0, 1'b1);
         first = 0;
         if (w[19:18] == 2'b10) begin
            push(10, w, 1'b0, 1'b0, 1'b0);          // R10 idle after end
            break;
         end
         if (w[19:18] == 2'b01)
            for (int k = 0; k < STALL; k++) push(6, w, 1'b0, 1'b1, 1'b1); // R6
         if (pc == DEPTH - 1) begin pc = 0; wrapped = 1; end
         else pc = pc + 1;
      end
   endtask

   // Monitor: pops one expected item per cycle, sampled at the falling edge.
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(int'(e.req), "busy",      int'(busy),       int'(e.bz));
         chk(int'(e.req), "ram_we",    int'(ram_we),     int'(e.we));
         chk(int'(e.req), "addr_a",    int'(ram_addr_a), int'(e.a));
         chk(int'(e.req), "addr_b",    int'(ram_addr_b), int'(e.b));
         chk(int'(e.req), "unit_load", int'(unit_load),  int'(e.ld));
         chk(4,           "unit_oe",   int'(unit_oe),    int'(e.oe));  // R4
         chk(7,           "done",      int'(done),       int'(e.dn));  // R7
         chk(6,           "mul_wait",  int'(mul_wait),   int'(e.mw));  // R6
      end
   end

   // Run a routine; optionally inject a start while busy (R8).
   task automatic run(input int addr, input int poke_cycle, input int poke_addr);
      @(negedge clk);
      start_addr = AW'(addr);
      start = 1'b1;
      @(posedge clk);
      plan(addr, (poke_cycle >= 0) ? 8 : 0);
      @(negedge clk);
      start = 1'b0;
      for (int c = 1; q.size() > 0 && c < 400; c++) begin
         if (c == poke_cycle) begin
            start_addr = AW'(poke_addr);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
   end

   initial begin : main
      start = 1'b1;          // start held during reset must not matter
      start_addr = 5'd5;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(1, "busy",      int'(busy),       0);
      chk(1, "done",      int'(done),       0);
      chk(1, "mul_wait",  int'(mul_wait),   0);
      chk(1, "ram_we",    int'(ram_we),     0);
      chk(1, "unit_oe",   int'(unit_oe),    0);
      chk(1, "unit_load", int'(unit_load),  0);
      chk(1, "addr_a",    int'(ram_addr_a), 0);
      chk(1, "addr_b",    int'(ram_addr_b), 0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(1, "busy after release", int'(busy), 0);

      run(0, -1, 0);     // advance, stall, out-of-range select, end
      run(5, -1, 0);     // reserved code advances, second stall
      run(29, 3, 5);     // wrap past top; start while busy ignored (R8)
      run(0, 4, 29);     // start during a multiply wait ignored (R8)
      repeat (3) @(negedge clk);
      // R10: stays idle and quiet without a start
      chk(10, "busy idle",   int'(busy),    0);
      chk(10, "ram_we idle", int'(ram_we),  0);
      chk(10, "oe idle",     int'(unit_oe), 0);
      finish_up();
   end

endmodule